// File: doc/BRIEF.md
# Anti-Modulation Transmit Level Encoder

This block is the digital model of a transmit drive stage for a frequency-hopping radio synthesiser. Transmit data bits arrive one per strobe. Each bit becomes a three-level drive code that stands for zero, half or full modulation current. While the transmitter ramps up or down, and for the whole of receive, the code is forced to the half level. Because of this, the loop never settles on either data polarity, and the first bits of a burst are not overmodulated.

Beside the drive path, a signed saturating integrator follows the running imbalance of the data. A low bit pushes it up one unit and a high bit pulls it down one unit. The value is scaled by a fixed gain into a registered correction term, which the loop adds to the phase detector output. This counters the drift back to centre frequency when the data is not balanced. In receive mode the integrator is held at zero, its reference level.

Bits enter on a valid/ready stream. The block never back-pressures: `in_ready` is high whenever reset is released. A bit is accepted on any rising clock edge where `in_valid` and `in_ready` are both high. Mode pins and the outputs are plain signals.

Top module: `amod_encoder`

## Requirements
- R1: In transmit (`tx_sel`=1) with `ramp`=0, an accepted bit of 1 gives `drive_o`=2'b00 (zero current) from the next clock edge.
- R2: In transmit with `ramp`=0, an accepted bit of 0 gives `drive_o`=2'b10 (full current) from the next clock edge.
- R3: While `ramp`=1, `drive_o` becomes 2'b01 (half current) at the next clock edge, whatever the data.
- R4: While `tx_sel`=0 (receive), `drive_o` becomes 2'b01 at the next clock edge, whatever the data.
- R5: `drive_o` never shows 2'b11.
- R6: In transmit with `ramp`=0, an accepted 0 bit adds one to `integ_o` and an accepted 1 bit subtracts one, at the accepting edge.
- R7: `integ_o` saturates at +SAT_LIM and -SAT_LIM (default 32). A further bit in the same direction leaves it unchanged.
- R8: While `tx_sel`=0, `integ_o` is zero after each clock edge, and accepted bits do not move it.
- R9: While `tx_sel`=1 and `ramp`=1, `integ_o` holds its value through accepted bits.
- R10: `corr_o` equals GAIN times the `integ_o` value of the previous cycle, as a signed two's-complement number (default GAIN=3).
- R11: `in_ready` is high whenever `rst_n` is high. With `in_valid`=0 the integrator holds, and the drive keeps using the last accepted bit.
- R12: During reset (`rst_n`=0), `drive_o`=2'b01, `integ_o`=0, `corr_o`=0 and `in_ready`=0. The held bit resets to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_sel | input | 1 | 1 = transmit, 0 = receive |
| ramp | input | 1 | Transmitter power ramp in progress |
| in_valid | input | 1 | Bit strobe valid |
| in_ready | output | 1 | Bit strobe ready (high out of reset) |
| in_bit | input | 1 | Transmit data bit |
| drive_o | output | 2 | Drive code: 00 zero, 01 half, 10 full |
| integ_o | output | INT_W | Signed compensation integral |
| corr_o | output | CORR_W | Signed loop correction, GAIN x integral |

## Verification
The bench drives long runs of equal bits past both saturation limits. A design that wraps instead of clamping would flip the sign of the correction at that point. Mode changes arrive while strobes are active. A design that integrated during the ramp, or that failed to clear in receive, would start the next burst off the reference value. Strobe-free cycles check that the drive keeps using the held bit. Every step compares the correction against the previous cycle's modelled integral, which exposes a missing pipeline stage or a gain applied to an unsigned value.

// File: rtl/amod_pkg.sv
package amod_pkg;
  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_HALF = 2'b01,
    LVL_FULL = 2'b10
  } drive_lvl_e;

  function automatic drive_lvl_e pick_level(input logic tx, input logic rmp, input logic bit_v);
    if (!tx || rmp) return LVL_HALF;
    return bit_v ? LVL_ZERO : LVL_FULL;
  endfunction
endpackage

// File: rtl/amod_level_sel.sv
module amod_level_sel
  import amod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_sel,
  input  logic       ramp,
  input  logic       take,
  input  logic       bit_in,
  output drive_lvl_e drive_o
);
  logic held_q;
  logic cur_bit;

  assign cur_bit = take ? bit_in : held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q  <= 1'b1;
      drive_o <= LVL_HALF;
    end else begin
      if (take) held_q <= bit_in;
      drive_o <= pick_level(tx_sel, ramp, cur_bit);
    end
  end
endmodule

// File: rtl/amod_integrator.sv
module amod_integrator #(
  parameter int SAT_LIM = 32,
  parameter int INT_W   = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tx_sel,
  input  logic                    ramp,
  input  logic                    take,
  input  logic                    bit_in,
  output logic signed [INT_W-1:0] integ_o
);
  localparam logic signed [INT_W-1:0] LIM_P = INT_W'(SAT_LIM);
  localparam logic signed [INT_W-1:0] LIM_N = -LIM_P;
  localparam logic signed [INT_W-1:0] ONE   = INT_W'(1);

  logic at_top, at_bot;
  assign at_top = (integ_o == LIM_P);
  assign at_bot = (integ_o == LIM_N);

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_sel) begin
      integ_o <= '0;
    end else if (take && !ramp) begin
      if (!bit_in && !at_top)     integ_o <= integ_o + ONE;
      else if (bit_in && !at_bot) integ_o <= integ_o - ONE;
    end
  end
endmodule

// File: rtl/amod_corr_scale.sv
module amod_corr_scale #(
  parameter int INT_W  = 7,
  parameter int GAIN_W = 4,
  parameter int GAIN   = 3,
  parameter int CORR_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [INT_W-1:0]  integ_i,
  output logic signed [CORR_W-1:0] corr_o
);
  localparam logic signed [CORR_W-1:0] GAIN_S = CORR_W'(GAIN);

  logic signed [CORR_W-1:0] integ_ext;
  logic signed [CORR_W-1:0] prod;

  assign integ_ext = CORR_W'(integ_i);
  assign prod      = integ_ext * GAIN_S;

  always_ff @(posedge clk) begin
    if (!rst_n) corr_o <= '0;
    else        corr_o <= prod;
  end
endmodule

// File: rtl/amod_encoder.sv
module amod_encoder
  import amod_pkg::*;
#(
  parameter int SAT_LIM = 32,
  parameter int GAIN_W  = 4,
  parameter int GAIN    = 3,
  localparam int INT_W  = $clog2(SAT_LIM + 1) + 1,
  localparam int CORR_W = INT_W + GAIN_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tx_sel,
  input  logic                     ramp,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_bit,
  output logic [1:0]               drive_o,
  output logic signed [INT_W-1:0]  integ_o,
  output logic signed [CORR_W-1:0] corr_o
);
  logic       take;
  drive_lvl_e lvl;

  assign in_ready = rst_n;
  assign take     = in_valid && in_ready;
  assign drive_o  = lvl;

  amod_level_sel u_lvl (
    .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel), .ramp(ramp),
    .take(take), .bit_in(in_bit), .drive_o(lvl)
  );

  amod_integrator #(.SAT_LIM(SAT_LIM), .INT_W(INT_W)) u_int (
    .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel), .ramp(ramp),
    .take(take), .bit_in(in_bit), .integ_o(integ_o)
  );

  amod_corr_scale #(.INT_W(INT_W), .GAIN_W(GAIN_W), .GAIN(GAIN), .CORR_W(CORR_W)) u_corr (
    .clk(clk), .rst_n(rst_n), .integ_i(integ_o), .corr_o(corr_o)
  );
endmodule

// File: rtl/amod_encoder_chk.sv
module amod_encoder_chk #(
  parameter int SAT_LIM = 32,
  parameter int GAIN_W  = 4,
  parameter int GAIN    = 3,
  localparam int INT_W  = $clog2(SAT_LIM + 1) + 1,
  localparam int CORR_W = INT_W + GAIN_W + 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tx_sel,
  input logic                     ramp,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     in_bit,
  input logic [1:0]               drive_o,
  input logic signed [INT_W-1:0]  integ_o,
  input logic signed [CORR_W-1:0] corr_o
);
  localparam logic signed [INT_W-1:0]  LIM_P  = INT_W'(SAT_LIM);
  localparam logic signed [INT_W-1:0]  LIM_N  = -LIM_P;
  localparam logic signed [CORR_W-1:0] GAIN_S = CORR_W'(GAIN);

  logic signed [CORR_W-1:0] integ_w;
  logic take;
  assign integ_w = CORR_W'(integ_o);
  assign take    = in_valid && in_ready;

  a_r5_no_code3: assert property (@(posedge clk) disable iff (!rst_n) drive_o != 2'b11);
  a_r4_rx_half: assert property (@(posedge clk) disable iff (!rst_n) !tx_sel |=> drive_o == 2'b01);
  a_r3_ramp_half: assert property (@(posedge clk) disable iff (!rst_n) ramp |=> drive_o == 2'b01);
  a_r8_rx_zero: assert property (@(posedge clk) disable iff (!rst_n) !tx_sel |=> integ_o == '0);
  a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n) integ_o <= LIM_P && integ_o >= LIM_N);
  a_r6_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tx_sel && !ramp && !in_bit && integ_o != LIM_P) |=> integ_o == $past(integ_o) + INT_W'(1));
  a_r9_ramp_hold: assert property (@(posedge clk) disable iff (!rst_n) (tx_sel && ramp) |=> $stable(integ_o));
  a_r10_gain: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> corr_o == $past(integ_w) * GAIN_S);
  a_r11_ready: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
endmodule

bind amod_encoder amod_encoder_chk #(.SAT_LIM(SAT_LIM), .GAIN_W(GAIN_W), .GAIN(GAIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel), .ramp(ramp), .in_valid(in_valid),
  .in_ready(in_ready), .in_bit(in_bit), .drive_o(drive_o), .integ_o(integ_o), .corr_o(corr_o)
);

// File: tb/amod_encoder_test.sv
module amod_encoder_test;
  localparam int CLK_P   = 10;
  localparam int SAT_LIM = 32;
  localparam int GAIN_W  = 4;
  localparam int GAIN    = 3;
  localparam int INT_W   = $clog2(SAT_LIM + 1) + 1;
  localparam int CORR_W  = INT_W + GAIN_W + 1;

  logic clk = 1'b0, rst_n = 1'b0, tx_sel = 1'b0, ramp = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic in_ready;
  logic [1:0] drive_o;
  logic signed [INT_W-1:0]  integ_o;
  logic signed [CORR_W-1:0] corr_o;

  amod_encoder uut (
    .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel), .ramp(ramp), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .drive_o(drive_o), .integ_o(integ_o), .corr_o(corr_o)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic [1:0] drv;
    int         itg;
    int         cor;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;
  int m_int = 0;
  logic m_bit = 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic b, input logic tx, input logic rp, input string tag);
    exp_t e;
    int prev;
    #1;
    in_valid = v; in_bit = b; tx_sel = tx; ramp = rp;
    @(posedge clk);
    prev = m_int;
    if (!tx) m_int = 0;
    else if (v && !rp) begin
      if (!b && m_int < SAT_LIM) m_int++;
      else if (b && m_int > -SAT_LIM) m_int--;
    end
    if (v) m_bit = b;
    e.drv = (!tx || rp) ? 2'b01 : (m_bit ? 2'b00 : 2'b10);
    e.itg = m_int;
    e.cor = prev * GAIN;
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(drive_o == e.drv, {e.tag, " drive"}, int'(drive_o), int'(e.drv));
      chk(drive_o != 2'b11, "R5 code", int'(drive_o), 0);
      chk(int'(integ_o) == e.itg, {e.tag, " integ"}, int'(integ_o), e.itg);
      chk(int'(corr_o) == e.cor, "R10 corr", int'(corr_o), e.cor);
      chk(in_ready == 1'b1, "R11 ready", int'(in_ready), 1);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(drive_o == 2'b01, "R12 reset drive", int'(drive_o), 1);
    chk(integ_o == '0, "R12 reset integ", int'(integ_o), 0);
    chk(corr_o == '0, "R12 reset corr", int'(corr_o), 0);
    chk(in_ready == 1'b0, "R12 reset ready", int'(in_ready), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    // ramp in transmit: half level, integrator frozen
    for (int i = 0; i < 4; i++) step(1'b1, i[0], 1'b1, 1'b1, "R3 R9 ramp");
    // low bits raise, full drive
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, 1'b0, "R2 R6 low");
    // high bits lower, zero drive
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R1 R6 high");
    // idle cycles hold
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, 1'b0, "R11 idle");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R2 R6 low");
    for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 1'b1, 1'b0, "R11 idle");
    // positive saturation
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b1, 1'b0, "R7 top");
    // ramp with non-zero value
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b1, "R9 hold");
    // negative saturation
    for (int i = 0; i < 70; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R7 bottom");
    // alternating pattern
    for (int i = 0; i < 8; i++) step(1'b1, i[0], 1'b1, 1'b0, "R6 alt");
    // receive: cleared and forced half
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R4 R8 rx");
    step(1'b1, 1'b1, 1'b0, 1'b1, "R4 R8 rx");
    // back to transmit from reference
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, 1'b0, "R8 R6 resume");
    #1 in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule